// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block keeps the per-slot bookkeeping for one storage port. The port has 32 command slots by default. Software marks slots as issued, and marks a slot as queued-active when the command in it is a queued command. While the port's start control is high, the scheduler offers the lowest-numbered slot that is issued and not yet in flight to a command executor, one offer at a time, over a valid/ready handshake. When the executor accepts a slot, the block records that slot as the current slot. For a long operation, the executor also flags the slot as in flight.

The executor later reports completions by slot index. A completing non-queued command drops its issue bit. A completing queued command drops its active bit, and the block emits a one-hot set-device-bits completion word. When start is lowered, every in-flight slot is torn down. The running flag stays high until the first cycle in which start is low and nothing is in flight. A command-list-override request produces a one-cycle acknowledge.

Top module: `slot_sched`

## Requirements
- R1: While `start_i` is high, `disp_valid_o` offers the lowest slot index whose issue bit is set and whose pending bit is clear. No offer is made while `start_i` is low or while no such slot exists.
- R2: Once an offer is shown, its slot index stays unchanged and the offer stays valid until `disp_ready_i` accepts it, unless `start_i` drops.
- R3: An accepted offer writes its slot index to `cur_slot_o` at the accepting clock edge.
- R4: At acceptance with `disp_long_i`=1, the slot's pending bit is set. Its issue bit is kept if the slot's active bit is 0 and cleared if the active bit is 1. At acceptance with `disp_long_i`=0, the issue bit is cleared and the pending bit stays 0.
- R5: A completion (`done_valid_i`, `done_slot_i`) for a pending slot whose active bit is 0 clears that slot's pending and issue bits at that edge. No completion word is emitted.
- R6: A completion for a pending slot whose active bit is 1 clears its pending and active bits. On the following cycle, `sdb_valid_o` is high for one cycle with `sdb_mask_o` equal to 1 shifted left by the slot index.
- R7: A completion naming a slot whose pending bit is clear changes no mask and emits no completion word.
- R8: At each edge where `start_i` is low, every slot that was pending loses its pending, issue and active bits. Issued slots that were not pending keep their issue bit.
- R9: `running_o` is set at any edge with `start_i` high. It is cleared, together with `cur_slot_o` going to 0, at the first edge where `start_i` is low and the pending mask was already empty. If slots were in flight when start fell, this happens one cycle later.
- R10: `clo_o` is high exactly in the cycle after each cycle in which `clo_req_i` is high. Otherwise it is low.
- R11: After reset, all masks, the offer, `running_o`, `cur_slot_o`, `clo_o` and the completion word are zero.
- R12: `issue_set_i` and `active_set_i` bits are ORed into the issue and active masks. They are applied after any clearing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Port start control (level) |
| clo_req_i | input | 1 | Command-list-override request |
| issue_set_i | input | NUM_SLOTS | Slots to mark as issued |
| active_set_i | input | NUM_SLOTS | Slots to mark as queued-active |
| disp_valid_o | output | 1 | Slot offer valid |
| disp_ready_i | input | 1 | Executor accepts the offer |
| disp_long_i | input | 1 | Accepted slot is a long (in-flight) operation |
| disp_slot_o | output | SLOT_W | Offered slot index |
| done_valid_i | input | 1 | Completion report valid |
| done_slot_i | input | SLOT_W | Completing slot index |
| issue_o | output | NUM_SLOTS | Issue mask |
| pending_o | output | NUM_SLOTS | In-flight mask |
| active_o | output | NUM_SLOTS | Queued-active mask |
| running_o | output | 1 | Command list running flag |
| cur_slot_o | output | SLOT_W | Last dispatched slot |
| clo_o | output | 1 | Override acknowledge pulse |
| sdb_valid_o | output | 1 | Set-device-bits completion word valid |
| sdb_mask_o | output | NUM_SLOTS | One-hot slot mask of the completion word |

## Verification
The directed part of the bench uses several stimuli. Two slots are issued at once, which shows whether the scan picks the lower index. The executor stalls an offer, which exposes an offer that moves. A long non-queued acceptance is compared with a short one and with a queued one, which separates the three issue-bit outcomes. A completion names an idle slot, which shows whether stray completions are filtered. Start is dropped with one slot in flight and one only issued, which separates the teardown of in-flight slots from that of waiting slots, and which shows the one-cycle lag of the running flag. The random phase mixes sparse issue bursts, random acceptance and length, completions of random in-flight slots and short stop windows, and compares every output cycle by cycle against a bench model.

// File: rtl/ssched_pkg.sv
package ssched_pkg;
    localparam int MAX_SLOTS = 32;

    typedef enum logic [1:0] {
        DONE_NONE   = 2'd0,
        DONE_LEGACY = 2'd1,
        DONE_QUEUED = 2'd2
    } done_kind_e;

    typedef struct packed {
        logic running;
        logic clo;
        logic sdb_valid;
    } run_flags_t;
endpackage

// File: rtl/ssched_pick.sv
module ssched_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] cand_i,
    output logic                 found_o,
    output logic [SLOT_W-1:0]    idx_o
);
    logic [NUM_SLOTS-1:0] first;

    // ascending scan: the first candidate wins
    always_comb begin
        logic below;
        below = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            first[i] = cand_i[i] & ~below;
            below    = below | cand_i[i];
        end
        found_o = below;
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (first[i]) idx_o = idx_o | SLOT_W'(i);
        end
    end
endmodule

// File: rtl/ssched_slots.sv
module ssched_slots
    import ssched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_SLOTS-1:0] issue_set_i,
    input  logic [NUM_SLOTS-1:0] active_set_i,
    input  logic                 fire_i,
    input  logic [SLOT_W-1:0]    fire_slot_i,
    input  logic                 fire_long_i,
    input  logic                 done_valid_i,
    input  logic [SLOT_W-1:0]    done_slot_i,
    output logic [NUM_SLOTS-1:0] issue_q_o,
    output logic [NUM_SLOTS-1:0] pending_q_o,
    output logic [NUM_SLOTS-1:0] active_q_o,
    output logic [NUM_SLOTS-1:0] cand_d_o,
    output done_kind_e           done_kind_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] issue;
        logic [NUM_SLOTS-1:0] pending;
        logic [NUM_SLOTS-1:0] active;
    } masks_t;

    masks_t masks_d, masks_q;
    logic [NUM_SLOTS-1:0] nxt_iss, nxt_pen, nxt_act;

    // per-slot next state: completion, then dispatch, then stop, then sets
    function automatic logic [2:0] slot_next(
        input logic iss, input logic pen, input logic act,
        input logic hit_done, input logic hit_fire, input logic long_op,
        input logic run, input logic set_iss, input logic set_act
    );
        logic i_n, p_n, a_n;
        i_n = iss;
        p_n = pen;
        a_n = act;
        if (hit_done) begin
            p_n = 1'b0;
            if (act) a_n = 1'b0;
            else     i_n = 1'b0;
        end
        if (hit_fire) begin
            if (long_op) p_n = 1'b1;
            if (!long_op || act) i_n = 1'b0;
        end
        if (!run) begin
            if (pen) begin
                i_n = 1'b0;
                a_n = 1'b0;
            end
            p_n = 1'b0;
        end
        i_n = i_n | set_iss;
        a_n = a_n | set_act;
        return {a_n, p_n, i_n};
    endfunction

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic hit_done, hit_fire;
            assign hit_done = done_valid_i && (done_slot_i == SLOT_W'(s)) && masks_q.pending[s];
            assign hit_fire = fire_i && (fire_slot_i == SLOT_W'(s));
            assign {nxt_act[s], nxt_pen[s], nxt_iss[s]} = slot_next(
                masks_q.issue[s], masks_q.pending[s], masks_q.active[s],
                hit_done, hit_fire, fire_long_i, start_i,
                issue_set_i[s], active_set_i[s]);
        end
    endgenerate

    always_comb begin
        masks_d.issue   = nxt_iss;
        masks_d.pending = nxt_pen;
        masks_d.active  = nxt_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) masks_q <= '0;
        else        masks_q <= masks_d;
    end

    always_comb begin
        if (done_valid_i && masks_q.pending[done_slot_i]) begin
            done_kind_o = masks_q.active[done_slot_i] ? DONE_QUEUED : DONE_LEGACY;
        end else begin
            done_kind_o = DONE_NONE;
        end
    end

    assign cand_d_o    = masks_d.issue & ~masks_d.pending;
    assign issue_q_o   = masks_q.issue;
    assign pending_q_o = masks_q.pending;
    assign active_q_o  = masks_q.active;
endmodule

// File: rtl/ssched_run.sv
module ssched_run
    import ssched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 idle_i,
    input  logic                 fire_i,
    input  logic [SLOT_W-1:0]    fire_slot_i,
    input  logic                 clo_req_i,
    input  done_kind_e           done_kind_i,
    input  logic [SLOT_W-1:0]    done_slot_i,
    output logic                 running_o,
    output logic [SLOT_W-1:0]    cur_slot_o,
    output logic                 clo_o,
    output logic                 sdb_valid_o,
    output logic [NUM_SLOTS-1:0] sdb_mask_o
);
    typedef struct packed {
        run_flags_t           flags;
        logic [SLOT_W-1:0]    cur;
        logic [NUM_SLOTS-1:0] sdb_mask;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (start_i)     run_d.flags.running = 1'b1;
        else if (idle_i) run_d.flags.running = 1'b0;

        if (fire_i)                run_d.cur = fire_slot_i;
        else if (!start_i && idle_i) run_d.cur = '0;

        run_d.flags.clo       = clo_req_i;
        run_d.flags.sdb_valid = (done_kind_i == DONE_QUEUED);
        run_d.sdb_mask        = '0;
        if (done_kind_i == DONE_QUEUED) run_d.sdb_mask[done_slot_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign running_o   = run_q.flags.running;
    assign cur_slot_o  = run_q.cur;
    assign clo_o       = run_q.flags.clo;
    assign sdb_valid_o = run_q.flags.sdb_valid;
    assign sdb_mask_o  = run_q.sdb_mask;
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import ssched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 clo_req_i,
    input  logic [NUM_SLOTS-1:0] issue_set_i,
    input  logic [NUM_SLOTS-1:0] active_set_i,
    output logic                 disp_valid_o,
    input  logic                 disp_ready_i,
    input  logic                 disp_long_i,
    output logic [SLOT_W-1:0]    disp_slot_o,
    input  logic                 done_valid_i,
    input  logic [SLOT_W-1:0]    done_slot_i,
    output logic [NUM_SLOTS-1:0] issue_o,
    output logic [NUM_SLOTS-1:0] pending_o,
    output logic [NUM_SLOTS-1:0] active_o,
    output logic                 running_o,
    output logic [SLOT_W-1:0]    cur_slot_o,
    output logic                 clo_o,
    output logic                 sdb_valid_o,
    output logic [NUM_SLOTS-1:0] sdb_mask_o
);
    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } offer_t;

    offer_t               offer_d, offer_q;
    logic                 fire;
    logic [NUM_SLOTS-1:0] cand_d;
    logic                 pick_found;
    logic [SLOT_W-1:0]    pick_idx;
    done_kind_e           done_kind;

    assign disp_valid_o = offer_q.valid & start_i;
    assign disp_slot_o  = offer_q.slot;
    assign fire         = disp_valid_o & disp_ready_i;

    ssched_slots #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .issue_set_i  (issue_set_i),
        .active_set_i (active_set_i),
        .fire_i       (fire),
        .fire_slot_i  (offer_q.slot),
        .fire_long_i  (disp_long_i),
        .done_valid_i (done_valid_i),
        .done_slot_i  (done_slot_i),
        .issue_q_o    (issue_o),
        .pending_q_o  (pending_o),
        .active_q_o   (active_o),
        .cand_d_o     (cand_d),
        .done_kind_o  (done_kind)
    );

    ssched_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
        .cand_i  (cand_d),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // offer register: reload only when empty or just accepted
    always_comb begin
        offer_d = offer_q;
        if (!start_i) begin
            offer_d.valid = 1'b0;
        end else if (!offer_q.valid || fire) begin
            offer_d.valid = pick_found;
            offer_d.slot  = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) offer_q <= '0;
        else        offer_q <= offer_d;
    end

    ssched_run #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .idle_i      (pending_o == '0),
        .fire_i      (fire),
        .fire_slot_i (offer_q.slot),
        .clo_req_i   (clo_req_i),
        .done_kind_i (done_kind),
        .done_slot_i (done_slot_i),
        .running_o   (running_o),
        .cur_slot_o  (cur_slot_o),
        .clo_o       (clo_o),
        .sdb_valid_o (sdb_valid_o),
        .sdb_mask_o  (sdb_mask_o)
    );
endmodule

// File: rtl/ssched_chk.sv
module ssched_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 clo_req_i,
    input logic                 disp_valid_o,
    input logic                 disp_ready_i,
    input logic [SLOT_W-1:0]    disp_slot_o,
    input logic [NUM_SLOTS-1:0] issue_o,
    input logic [NUM_SLOTS-1:0] pending_o,
    input logic                 running_o,
    input logic                 clo_o,
    input logic                 sdb_valid_o,
    input logic [NUM_SLOTS-1:0] sdb_mask_o
);
    // R1
    offer_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> (issue_o[disp_slot_o] && !pending_o[disp_slot_o]));

    // R2
    offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && !disp_ready_i) |=> (!start_i || (disp_valid_o && $stable(disp_slot_o))));

    // R6
    sdb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdb_valid_o |-> ($countones(sdb_mask_o) == 1));

    // R8
    stop_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (pending_o == '0));

    // R9
    inflight_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o != '0) |-> running_o);

    // R10
    clo_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clo_o |-> $past(clo_req_i));
endmodule

bind slot_sched ssched_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .clo_req_i    (clo_req_i),
    .disp_valid_o (disp_valid_o),
    .disp_ready_i (disp_ready_i),
    .disp_slot_o  (disp_slot_o),
    .issue_o      (issue_o),
    .pending_o    (pending_o),
    .running_o    (running_o),
    .clo_o        (clo_o),
    .sdb_valid_o  (sdb_valid_o),
    .sdb_mask_o   (sdb_mask_o)
);

// File: tb/sim_slot_sched.sv
`timescale 1ns/1ps
module sim_slot_sched;
    localparam int N = 32;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st = 1'b0, clo = 1'b0, rdy = 1'b0, lng = 1'b0, dv = 1'b0;
    logic [N-1:0] iset = '0, aset = '0;
    logic [W-1:0] ds = '0;

    logic         disp_valid, running, clo_o, sdb_valid;
    logic [W-1:0] disp_slot, cur_slot;
    logic [N-1:0] issue, pending, active, sdb_mask;

    int total = 0;
    int bad = 0;

    // bench model state
    logic [N-1:0] m_iss = '0, m_pen = '0, m_act = '0, m_sm = '0;
    logic         m_ov = 1'b0, m_run = 1'b0, m_clo = 1'b0, m_sv = 1'b0;
    logic [W-1:0] m_os = '0, m_cur = '0;

    always #5 clk = ~clk;

    slot_sched u0 (
        .clk(clk), .rst_n(rst_n), .start_i(st), .clo_req_i(clo),
        .issue_set_i(iset), .active_set_i(aset),
        .disp_valid_o(disp_valid), .disp_ready_i(rdy), .disp_long_i(lng),
        .disp_slot_o(disp_slot), .done_valid_i(dv), .done_slot_i(ds),
        .issue_o(issue), .pending_o(pending), .active_o(active),
        .running_o(running), .cur_slot_o(cur_slot), .clo_o(clo_o),
        .sdb_valid_o(sdb_valid), .sdb_mask_o(sdb_mask)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        clo = 1'b0; rdy = 1'b0; lng = 1'b0; dv = 1'b0;
        iset = '0; aset = '0; ds = '0;
    endtask

    // advance one cycle, predicting outputs from the requirements
    task automatic step();
        logic [N-1:0] ni, np, na, cand;
        logic fire, dhit, dq, found, idle;
        logic [W-1:0] pick;
        ni = m_iss; np = m_pen; na = m_act;
        fire = m_ov && st && rdy;
        dhit = dv && m_pen[ds];
        dq = dhit && m_act[ds];
        if (dhit) begin
            np[ds] = 1'b0;
            if (m_act[ds]) na[ds] = 1'b0; else ni[ds] = 1'b0;
        end
        if (fire) begin
            if (lng) np[m_os] = 1'b1;
            if (!lng || m_act[m_os]) ni[m_os] = 1'b0;
        end
        if (!st) begin
            ni = ni & ~m_pen;
            na = na & ~m_pen;
            np = '0;
        end
        ni = ni | iset;
        na = na | aset;
        cand = ni & ~np;
        found = 1'b0; pick = '0;
        for (int i = N - 1; i >= 0; i--) if (cand[i]) begin found = 1'b1; pick = W'(i); end
        idle = (m_pen == '0);
        @(posedge clk);
        #1;
        if (!st) m_ov = 1'b0;
        else if (!m_ov || fire) begin m_ov = found; m_os = pick; end
        if (fire) m_cur = m_os_prev(fire, pick);
        m_iss = ni; m_pen = np; m_act = na;
        m_clo = clo; m_sv = dq; m_sm = dq ? (N'(1) << ds) : '0;
        chk("R1 disp_valid", {63'd0, disp_valid}, {63'd0, m_ov && st});
        if (m_ov && st) chk("R1 disp_slot", 64'(disp_slot), 64'(m_os));
        chk("R4 issue mask", 64'(issue), 64'(m_iss));
        chk("R4 pending mask", 64'(pending), 64'(m_pen));
        chk("R6 active mask", 64'(active), 64'(m_act));
        chk("R6 sdb valid", {63'd0, sdb_valid}, {63'd0, m_sv});
        chk("R6 sdb mask", 64'(sdb_mask), 64'(m_sm));
        chk("R9 running", {63'd0, running}, {63'd0, m_run_next(idle)});
        chk("R9 cur slot", 64'(cur_slot), 64'(m_cur_next(fire, idle)));
        chk("R10 clo", {63'd0, clo_o}, {63'd0, m_clo});
    endtask

    // helper state for running and current slot
    logic [W-1:0] fired_slot = '0;
    function automatic logic [W-1:0] m_os_prev(input logic f, input logic [W-1:0] p);
        return fired_slot;
    endfunction
    function automatic logic m_run_next(input logic idle);
        if (st) m_run = 1'b1;
        else if (idle) m_run = 1'b0;
        return m_run;
    endfunction
    function automatic logic [W-1:0] m_cur_next(input logic f, input logic idle);
        if (!f && !st && idle) m_cur = '0;
        return m_cur;
    endfunction

    // capture the slot being accepted before the edge
    always @(negedge clk) fired_slot = m_os;

    task automatic done_on(input int s);
        dv = 1'b1; ds = W'(s);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 issue", 64'(issue), 64'd0);
        chk("R11 pending", 64'(pending), 64'd0);
        chk("R11 running", {63'd0, running}, 64'd0);
        chk("R11 disp_valid", {63'd0, disp_valid}, 64'd0);
        chk("R11 sdb", {63'd0, sdb_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        st = 1'b1; step();
        chk("R9 running after start", {63'd0, running}, 64'd1);

        clear_inputs(); iset = (N'(1) << 5) | (N'(1) << 2); step();
        chk("R12 issue set", 64'(issue), 64'h24);
        chk("R1 lowest picked", 64'(disp_slot), 64'd2);

        clear_inputs(); step(); step();
        chk("R2 offer held valid", {63'd0, disp_valid}, 64'd1);
        chk("R2 offer held slot", 64'(disp_slot), 64'd2);

        clear_inputs(); rdy = 1'b1; lng = 1'b1; step();
        chk("R3 cur slot", 64'(cur_slot), 64'd2);
        chk("R4 long keeps issue", 64'(issue), 64'h24);
        chk("R4 long sets pending", 64'(pending), 64'h4);
        chk("R1 next offer", 64'(disp_slot), 64'd5);

        clear_inputs(); rdy = 1'b1; lng = 1'b0; step();
        chk("R4 short clears issue", 64'(issue), 64'h4);
        chk("R3 cur slot short", 64'(cur_slot), 64'd5);

        clear_inputs(); done_on(9); step();
        chk("R7 stray done issue", 64'(issue), 64'h4);
        chk("R7 stray done pending", 64'(pending), 64'h4);
        chk("R7 stray done sdb", {63'd0, sdb_valid}, 64'd0);

        clear_inputs(); done_on(2); step();
        chk("R5 legacy done issue", 64'(issue), 64'h0);
        chk("R5 legacy done pending", 64'(pending), 64'h0);
        clear_inputs(); step();
        chk("R5 no sdb", {63'd0, sdb_valid}, 64'd0);

        clear_inputs(); iset = N'(1) << 7; aset = N'(1) << 7; step();
        clear_inputs(); rdy = 1'b1; lng = 1'b1; step();
        chk("R4 queued clears issue", 64'(issue), 64'h0);
        chk("R4 queued pending", 64'(pending), 64'h80);
        clear_inputs(); done_on(7); step();
        chk("R6 sdb valid", {63'd0, sdb_valid}, 64'd1);
        chk("R6 sdb mask", 64'(sdb_mask), 64'h80);
        chk("R6 active cleared", 64'(active), 64'h0);
        clear_inputs(); step();
        chk("R6 sdb one cycle", {63'd0, sdb_valid}, 64'd0);

        clear_inputs(); iset = (N'(1) << 1) | (N'(1) << 3); step();
        clear_inputs(); rdy = 1'b1; lng = 1'b1; step();
        clear_inputs(); st = 1'b0; step();
        chk("R8 pending dropped", 64'(pending), 64'h0);
        chk("R8 waiting slot kept", 64'(issue), 64'h8);
        chk("R8 no offer", {63'd0, disp_valid}, 64'd0);
        chk("R9 running lingers", {63'd0, running}, 64'd1);
        step();
        chk("R9 running cleared", {63'd0, running}, 64'd0);
        chk("R9 cur cleared", 64'(cur_slot), 64'd0);

        clear_inputs(); clo = 1'b1; step();
        chk("R10 clo pulse", {63'd0, clo_o}, 64'd1);
        clear_inputs(); step();
        chk("R10 clo self clears", {63'd0, clo_o}, 64'd0);

        // random phase
        void'($urandom(32'h5a17));
        st = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            clear_inputs();
            st = ((cyc % 97) < 3) ? 1'b0 : 1'b1;
            if ($urandom_range(3) == 0) begin
                int b;
                b = int'($urandom_range(N - 1));
                iset[b] = 1'b1;
                if ($urandom_range(2) == 0) aset[b] = 1'b1;
            end
            rdy = ($urandom_range(9) < 6);
            lng = ($urandom_range(9) < 7);
            clo = ($urandom_range(19) == 0);
            if ($urandom_range(9) < 4 && m_pen != '0) begin
                int r;
                r = int'($urandom_range(N - 1));
                for (int j = 0; j < N; j++) begin
                    if (!dv && m_pen[(r + j) % N]) done_on((r + j) % N);
                end
            end else if ($urandom_range(19) == 0) begin
                done_on(int'($urandom_range(N - 1)));
            end
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule